// File: doc/BRIEF.md
# Handshaked Word-to-Bit Serializer

This block takes a parallel word, whose width is set by a parameter, and presents it one bit at a time on a serial output. The most significant bit goes first. Both sides use a valid/ready pair. On the parallel side, `word_new` is the valid and `word_ready` is the ready. On the serial side, `bit_valid` is the valid and `bit_adv` is the ready. A word transfers on a cycle where `word_new` and `word_ready` are both high. A bit is consumed on a cycle where `bit_valid` and `bit_adv` are both high.

Back-pressure on the serial side works by holding `bit_adv` low. The presented bit, its index and `bit_valid` then stay frozen. `bit_adv` does nothing while no word is held. The serializer applies back-pressure to the parallel side by dropping `word_ready` while a word is being shifted out. A `word_new` strobe offered then is not taken, and upstream must keep offering the word until `word_ready` is high. `word_ready` also rises combinationally in the cycle the final bit is consumed. A word offered in that cycle is presented in the very next cycle, so a continuous stream has no empty bit slot.

The bit index output tells downstream logic which bit of the held word is on the line. It counts down from `WIDTH-1` to 0.

Top module: `bitstream_serializer`

## Requirements
- R1: After reset `bit_valid` is 0, `word_ready` is 1, `bit_out` is 0 and `bit_idx` is `WIDTH-1`.
- R2: A word on `word_in` is captured only on a cycle where `word_new` and `word_ready` are both 1. In the following cycle `bit_valid` is 1 and `bit_idx` is `WIDTH-1`.
- R3: While `bit_valid` is 1, `bit_out` equals bit number `bit_idx` of the captured word, where bit 0 is the least significant bit. The first bit presented is therefore the most significant bit.
- R4: `bit_idx` decreases by exactly one after each cycle with `bit_valid` and `bit_adv` both 1 and `bit_idx` above 0. In every other cycle with a word held, `bit_idx` and `bit_out` are unchanged.
- R5: `bit_valid` stays 1 from the cycle after a capture until the cycle in which bit 0 is consumed. It falls in the next cycle unless a new word is captured in that same cycle.
- R6: `word_ready` is 1 exactly when no word is held, or when bit 0 is being consumed in the current cycle (`bit_valid`, `bit_adv` and `bit_idx`==0).
- R7: A `word_new` strobe while `word_ready` is 0 is ignored. The held word, index and serial output are not disturbed.
- R8: When a word is captured in the cycle bit 0 of the previous word is consumed, the next cycle presents the new word's most significant bit with `bit_valid` still 1 and `bit_idx` at `WIDTH-1`.
- R9: While no word is held, `bit_adv` has no effect: `bit_valid` stays 0, `bit_out` stays 0 and `bit_idx` stays at `WIDTH-1`.
- R10: `WIDTH` may be any value from 1 to 64. With `WIDTH`=1 a word is a single bit presented at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_in | input | WIDTH | Parallel word offered by upstream |
| word_new | input | 1 | Upstream valid: `word_in` holds a new word |
| word_ready | output | 1 | Serializer can accept a word this cycle |
| bit_adv | input | 1 | Downstream ready: consume the presented bit |
| bit_out | output | 1 | Presented serial bit |
| bit_valid | output | 1 | `bit_out` carries a real bit of a held word |
| bit_idx | output | IDX_W | Position in the held word of the presented bit |

## Verification
A corrupted bit counter is visible in the same cycle. `bit_idx` leaves the strict count-down, and `bit_out` stops matching the expected bit of the word, since the serial output is selected by the counter. A lost or stuck occupancy flag shows within one cycle as `word_ready` and `bit_valid` disagreeing with the count of bits consumed: for example, ready high with no final bit being consumed, or valid dropping before bit 0 is taken. A word register disturbed by an ignored strobe shows at the next presented bit. The bench therefore compares every output on every cycle against a count of the words accepted and the bits consumed.

// File: rtl/sps_pkg.sv
package sps_pkg;

  // Occupancy of the serializer.
  typedef enum logic {
    SPS_IDLE  = 1'b0,
    SPS_SHIFT = 1'b1
  } sps_state_e;

  // Index width; never zero so a one-bit word still has an index port.
  function automatic int unsigned sps_idx_width(input int unsigned width);
    return (width > 1) ? $clog2(width) : 1;
  endfunction

endpackage

// File: rtl/sps_handshake.sv
module sps_handshake
  import sps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic word_new,
  input  logic bit_adv,
  input  logic last_bit,
  output logic loaded,
  output logic ready,
  output logic load_en,
  output logic reload,
  output logic step_en
);

  sps_state_e state_q, state_d;
  logic       consume;
  logic       finish;

  assign loaded  = (state_q == SPS_SHIFT);
  assign consume = loaded & bit_adv;
  assign finish  = consume & last_bit;
  assign ready   = ~loaded | finish;
  assign load_en = word_new & ready;
  assign reload  = load_en | finish;
  assign step_en = consume & ~last_bit;

  always_comb begin
    state_d = state_q;
    if (load_en) begin
      state_d = SPS_SHIFT;
    end else if (finish) begin
      state_d = SPS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SPS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/sps_bit_counter.sv
module sps_bit_counter #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             step_en,
  output logic [IDX_W-1:0] idx,
  output logic             last_bit
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= TOP_IDX;
    end else if (reload) begin
      idx_q <= TOP_IDX;
    end else if (step_en) begin
      idx_q <= idx_q - 1'b1;
    end
  end

  assign idx      = idx_q;
  assign last_bit = (idx_q == '0);

endmodule

// File: rtl/sps_word_reg.sv
module sps_word_reg #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] word_in,
  input  logic             loaded,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_out
);

  logic [WIDTH-1:0] word_q;
  logic             sel_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_en) begin
      word_q <= word_in;
    end
  end

  generate
    if (WIDTH == 1) begin : g_single
      assign sel_bit = word_q[0];
    end else begin : g_multi
      assign sel_bit = word_q[idx];
    end
  endgenerate

  assign bit_out = loaded & sel_bit;

endmodule

// File: rtl/bitstream_serializer.sv
module bitstream_serializer #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDX_W = sps_pkg::sps_idx_width(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] word_in,
  input  logic             word_new,
  output logic             word_ready,
  input  logic             bit_adv,
  output logic             bit_out,
  output logic             bit_valid,
  output logic [IDX_W-1:0] bit_idx
);

  logic loaded;
  logic load_en;
  logic reload;
  logic step_en;
  logic last_bit;

  sps_handshake u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_new (word_new),
    .bit_adv  (bit_adv),
    .last_bit (last_bit),
    .loaded   (loaded),
    .ready    (word_ready),
    .load_en  (load_en),
    .reload   (reload),
    .step_en  (step_en)
  );

  sps_bit_counter #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload   (reload),
    .step_en  (step_en),
    .idx      (bit_idx),
    .last_bit (last_bit)
  );

  sps_word_reg #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .word_in (word_in),
    .loaded  (loaded),
    .idx     (bit_idx),
    .bit_out (bit_out)
  );

  assign bit_valid = loaded;

endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             word_new,
  input logic             word_ready,
  input logic             bit_adv,
  input logic             bit_out,
  input logic             bit_valid,
  input logic [IDX_W-1:0] bit_idx
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

  AST_LOAD_STARTS_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    word_new && word_ready |=> bit_valid && bit_idx == TOP_IDX); // R2

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> bit_idx <= TOP_IDX); // R3

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && bit_adv && bit_idx != '0 |=>
      bit_valid && bit_idx == IDX_W'($past(bit_idx) - 1'b1)); // R4

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !bit_adv |=> bit_valid && $stable(bit_idx) && $stable(bit_out)); // R4

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && bit_adv && bit_idx == '0 && !word_new |=> !bit_valid); // R5

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> word_ready); // R6

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && (!bit_adv || bit_idx != '0) |-> !word_ready); // R6

  AST_IGNORED_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    word_new && !word_ready && !bit_adv |=> $stable(bit_out) && $stable(bit_idx)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid && !word_new |=> !bit_valid && !bit_out && bit_idx == TOP_IDX); // R9

endmodule

bind bitstream_serializer sps_checker #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_new   (word_new),
  .word_ready (word_ready),
  .bit_adv    (bit_adv),
  .bit_out    (bit_out),
  .bit_valid  (bit_valid),
  .bit_idx    (bit_idx)
);

// File: tb/sim_bitstream_serializer.sv
module sim_bitstream_serializer;

  localparam int W = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  word_in = '0;
  logic          word_new = 1'b0;
  logic          bit_adv = 1'b0;
  logic          word_ready, bit_out, bit_valid;
  logic [IW-1:0] bit_idx;

  logic          s_in = 1'b0, s_new = 1'b0, s_adv = 1'b0;
  logic          s_ready, s_out, s_valid;
  logic [0:0]    s_idx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bitstream_serializer #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .word_new(word_new),
    .word_ready(word_ready), .bit_adv(bit_adv), .bit_out(bit_out),
    .bit_valid(bit_valid), .bit_idx(bit_idx)
  );

  bitstream_serializer #(.WIDTH(1)) u1 (
    .clk(clk), .rst_n(rst_n), .word_in(s_in), .word_new(s_new),
    .word_ready(s_ready), .bit_adv(s_adv), .bit_out(s_out),
    .bit_valid(s_valid), .bit_idx(s_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    int  held, pos, cur, sent, cyc, w_off;
    bit  adv, offer, ready_e, b2b;
    repeat (3) @(negedge clk);
    #1;
    chk(bit_valid == 1'b0, "R1 valid", int'(bit_valid), 0);
    chk(word_ready == 1'b1, "R1 ready", int'(word_ready), 1);
    chk(bit_out == 1'b0, "R1 bit", int'(bit_out), 0);
    chk(bit_idx == IW'(W-1), "R1 idx", int'(bit_idx), W-1);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: advance requests with nothing held
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      bit_adv = 1'b1;
      #1;
      chk(bit_valid == 1'b0, "R9 valid", int'(bit_valid), 0);
      chk(bit_out == 1'b0, "R9 bit", int'(bit_out), 0);
      chk(bit_idx == IW'(W-1), "R9 idx", int'(bit_idx), W-1);
    end

    // Sweep every word value under four advance/offer patterns
    held = 0; pos = 0; cur = 0;
    for (int mode = 0; mode < 4; mode++) begin
      sent = 0; cyc = 0; b2b = 1'b0;
      while ((sent < 16 || held != 0) && cyc < 400) begin
        @(negedge clk);
        case (mode)
          0: adv = 1'b1;
          1: adv = (cyc % 2) == 1;
          2: adv = (cyc % 3) != 0;
          default: adv = (cyc % 2) == 0;
        endcase
        offer = (mode == 3) ? ((cyc % 4) == 0) : 1'b1;
        if (sent >= 16) offer = 1'b0;
        ready_e = (held == 0) || (pos == W-1 && adv);
        w_off = (sent * 7 + mode * 3) % 16;
        bit_adv  = adv;
        word_new = offer;
        word_in  = ready_e ? W'(w_off) : W'(~w_off);
        #1;
        chk(word_ready == ready_e, "R6 ready", int'(word_ready), int'(ready_e));
        chk(bit_valid == (held != 0), "R5 valid", int'(bit_valid), held);
        if (held != 0) begin
          chk(bit_idx == IW'(W-1-pos), b2b ? "R8 idx" : "R4 idx", int'(bit_idx), W-1-pos);
          chk(bit_out == 1'((cur >> (W-1-pos)) & 1),
              (!ready_e && offer) ? "R7 bit" : "R3 bit",
              int'(bit_out), (cur >> (W-1-pos)) & 1);
        end else begin
          chk(bit_out == 1'b0 && bit_idx == IW'(W-1), "R9 idle", int'(bit_idx), W-1);
        end
        b2b = 1'b0;
        if (held != 0 && adv) begin
          if (pos == W-1) held = 0; else pos++;
        end
        if (offer && ready_e) begin
          b2b = (held == 0) && (pos == W-1);
          held = 1; pos = 0; cur = w_off; sent++;
          b2b = b2b && adv;
        end
        cyc++;
      end
      chk(sent == 16, "R2 words", sent, 16);
    end
    @(negedge clk);
    word_new = 1'b0; bit_adv = 1'b0;

    // R10: one-bit word
    for (int v = 0; v < 2; v++) begin
      @(negedge clk);
      s_in = 1'(v); s_new = 1'b1; s_adv = 1'b0;
      @(negedge clk);
      s_new = 1'b0; s_in = ~s_in;
      #1;
      chk(s_valid == 1'b1 && s_idx == 1'b0, "R10 valid", int'(s_valid), 1);
      chk(s_out == 1'(v), "R10 bit", int'(s_out), v);
      chk(s_ready == 1'b0, "R10 busy", int'(s_ready), 0);
      s_adv = 1'b1;
      #1;
      chk(s_ready == 1'b1, "R10 ready", int'(s_ready), 1);
      @(negedge clk);
      s_adv = 1'b0;
      #1;
      chk(s_valid == 1'b0, "R10 drop", int'(s_valid), 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule